// File: doc/BRIEF.md
# PD transmit retry controller

This block runs one transmission that a host has requested on a USB Power Delivery port. When `start_i` is pulsed it captures three settings: a 3-bit frame type, a 2-bit automatic retry count and a byte count. It then asks the physical layer to send the frame through a level request and a done pulse. For message frames it waits for the acknowledgement (GoodCRC) pulse and retries on a timeout. The result is given as a single pulse on one of three alert outputs: success, discarded or failed.

Reset frames (Hard Reset and Cable Reset) are sent once and count as successful when the physical layer finishes. They never wait for an acknowledgement. The BIST carrier request makes no physical-layer handshake. Instead it raises `bist_active_o` for a fixed, parameterised number of cycles and then reports success. An incoming message seen in the launch cycle of an attempt pre-empts the transmission, which is then reported as discarded. Bit coding, CRC and message parsing are done elsewhere. Here, acknowledgement and receive detection arrive as single-cycle pulses.

Top module: `pd_tx_retry_ctrl`

## Requirements
- R1: Out of reset, and after a reset that cuts a transmission short, `busy_o`, `phy_req_o`, `bist_active_o` and all three alert outputs are 0, and no outcome pulse follows the reset.
- R2: An accepted message or reset frame raises `phy_req_o`. The request stays high until `phy_done_i` is seen. While it is high, `phy_type_o` carries the captured frame type with this encoding: 0 SOP, 1 SOP', 2 SOP'', 3 SOP_DBG', 4 SOP_DBG'', 5 Hard Reset, 6 Cable Reset, 7 BIST carrier.
- R3: For a message frame (types 0 to 4), an `ack_i` pulse produces one `alert_success_o` pulse when it arrives in any of the ACK_TIMEOUT_CYC cycles after the cycle in which `phy_done_i` was sampled.
- R4: When an attempt times out without an acknowledgement, the block launches another attempt while retries remain. The total number of requests is the retry field plus one (1 to 4).
- R5: When the last permitted attempt times out, the block gives one `alert_fail_o` pulse.
- R6: If `rx_msg_i` is high in the launch cycle (the cycle after the start, or after a timeout), that attempt is not requested and `alert_discard_o` pulses.
- R7: Hard Reset and Cable Reset give `alert_success_o` right after `phy_done_i`, with no acknowledgement. They are never retried, whatever the retry field holds, and their byte count is not checked.
- R8: The BIST carrier (type 7) never raises `phy_req_o`. It holds `bist_active_o` high for exactly BIST_CYC cycles and then gives `alert_success_o`.
- R9: A message frame with a byte count below 2 or above 30 (a 2-byte header plus at most seven 4-byte objects) fails at once. `alert_fail_o` pulses in the cycle after the start, and no request is made.
- R10: Each accepted start produces exactly one outcome pulse, unless a reset cuts it short. At most one alert is high in any cycle, and `busy_o` is low while an alert is high.
- R11: A `start_i` pulse while `busy_o` is high is ignored. The running transmission keeps its captured settings, and no second transmission follows.
- R12: An `ack_i` pulse that arrives after the acknowledgement window has closed has no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted only while idle |
| frame_type_i | input | 3 | Frame type code (see R2) |
| retry_cnt_i | input | 2 | Number of automatic retries, 0 to 3 |
| byte_cnt_i | input | CNT_W (8) | Message length in bytes |
| rx_msg_i | input | 1 | Incoming message detected |
| phy_done_i | input | 1 | Physical layer has finished sending the frame |
| ack_i | input | 1 | Acknowledgement received |
| phy_req_o | output | 1 | Send request to the physical layer |
| phy_type_o | output | 3 | Frame type of the current request |
| busy_o | output | 1 | A transmission is in progress |
| bist_active_o | output | 1 | BIST carrier window is open |
| alert_success_o | output | 1 | Pulse: transmission succeeded |
| alert_discard_o | output | 1 | Pulse: transmission discarded |
| alert_fail_o | output | 1 | Pulse: transmission failed |

## Verification
The bench builds the block with ACK_TIMEOUT_CYC = 8 and BIST_CYC = 20, in place of the millisecond-scale defaults. These short windows let it place an acknowledgement exactly on the last accepted cycle and also one cycle too late. It can then run all four attempts of a three-retry message to failure, and time the whole BIST carrier window, all within a few hundred cycles. A physical-layer model in the bench answers every request with a done pulse and counts the attempts, while the outcome pulses are counted independently.

// File: rtl/pd_txr_pkg.sv
// Shared types and sizes for the PD transmit retry controller.
// Assumes the 3-bit frame type encoding is fixed by the host interface.
package pd_txr_pkg;

    // Frame type codes as written by the host.
    typedef enum logic [2:0] {
        FT_SOP       = 3'd0,
        FT_SOP_P     = 3'd1,
        FT_SOP_PP    = 3'd2,
        FT_DBG_P     = 3'd3,
        FT_DBG_PP    = 3'd4,
        FT_HARD_RST  = 3'd5,
        FT_CABLE_RST = 3'd6,
        FT_BIST_CARR = 3'd7
    } frame_kind_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_SEND,
        ST_WAIT_ACK,
        ST_BIST
    } txr_state_e;

    localparam int unsigned HDR_BYTES = 2;
    localparam int unsigned OBJ_BYTES = 4;
    localparam int unsigned MAX_OBJS  = 7;
    localparam int unsigned MSG_MIN_BYTES = HDR_BYTES;
    localparam int unsigned MSG_MAX_BYTES = HDR_BYTES + MAX_OBJS * OBJ_BYTES;

endpackage

// File: rtl/pd_txr_cfg_check.sv
// Classifies the requested frame type and validates the byte count.
// Purely combinational; assumes inputs are only used in the start cycle.
module pd_txr_cfg_check
    import pd_txr_pkg::*;
#(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned MIN_BYTES = MSG_MIN_BYTES,
    parameter int unsigned MAX_BYTES = MSG_MAX_BYTES
) (
    input  logic [2:0]       frame_type_i,
    input  logic [CNT_W-1:0] byte_cnt_i,
    output logic             is_reset_o,
    output logic             is_bist_o,
    output logic             count_ok_o
);

    logic in_range;

    // Decode the frame class and check the message length window.
    always_comb begin
        is_reset_o = (frame_type_i == FT_HARD_RST) || (frame_type_i == FT_CABLE_RST);
        is_bist_o  = (frame_type_i == FT_BIST_CARR);
        in_range   = (32'(byte_cnt_i) >= MIN_BYTES) && (32'(byte_cnt_i) <= MAX_BYTES);
        count_ok_o = is_reset_o || is_bist_o || in_range;
    end

endmodule

// File: rtl/pd_txr_window.sv
// Cycle window timer: counts while run_i is high and flags the last cycle.
// Assumes run_i drops after expiry; the count clears whenever run_i is low.
module pd_txr_window #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    // Flag the final cycle of the window.
    assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

    // Advance while running, clear while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pd_txr_fsm.sv
// Transmit sequencer: captures a request, launches attempts, handles
// retries, reset frames and the BIST carrier, and emits one outcome pulse.
// Assumes ack and rx pulses are already synchronous to clk.
module pd_txr_fsm
    import pd_txr_pkg::*;
#(
    parameter int unsigned RETRY_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [2:0]         frame_type_i,
    input  logic [RETRY_W-1:0] retry_i,
    input  logic               is_reset_i,
    input  logic               is_bist_i,
    input  logic               count_ok_i,
    input  logic               rx_msg_i,
    input  logic               phy_done_i,
    input  logic               ack_i,
    input  logic               ack_expired_i,
    input  logic               bist_expired_i,
    output logic               phy_req_o,
    output logic [2:0]         phy_type_o,
    output logic               ack_run_o,
    output logic               bist_run_o,
    output logic               busy_o,
    output logic               alert_success_o,
    output logic               alert_discard_o,
    output logic               alert_fail_o
);

    txr_state_e         state_q;
    logic [2:0]         type_q;
    logic               reset_q;
    logic               bist_q;
    logic [RETRY_W-1:0] left_q;

    // State-derived outputs towards the PHY, timers and host.
    always_comb begin
        phy_req_o  = (state_q == ST_SEND);
        phy_type_o = type_q;
        ack_run_o  = (state_q == ST_WAIT_ACK);
        bist_run_o = (state_q == ST_BIST);
        busy_o     = (state_q != ST_IDLE);
    end

    // Sequence one transmission and register the outcome pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q         <= ST_IDLE;
            type_q          <= '0;
            reset_q         <= 1'b0;
            bist_q          <= 1'b0;
            left_q          <= '0;
            alert_success_o <= 1'b0;
            alert_discard_o <= 1'b0;
            alert_fail_o    <= 1'b0;
        end else begin
            alert_success_o <= 1'b0;
            alert_discard_o <= 1'b0;
            alert_fail_o    <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (!count_ok_i) begin
                            alert_fail_o <= 1'b1;
                        end else begin
                            type_q  <= frame_type_i;
                            reset_q <= is_reset_i;
                            bist_q  <= is_bist_i;
                            left_q  <= retry_i;
                            state_q <= ST_LAUNCH;
                        end
                    end
                end
                ST_LAUNCH: begin
                    if (rx_msg_i) begin
                        alert_discard_o <= 1'b1;
                        state_q         <= ST_IDLE;
                    end else if (bist_q) begin
                        state_q <= ST_BIST;
                    end else begin
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (phy_done_i) begin
                        if (reset_q) begin
                            alert_success_o <= 1'b1;
                            state_q         <= ST_IDLE;
                        end else begin
                            state_q <= ST_WAIT_ACK;
                        end
                    end
                end
                ST_WAIT_ACK: begin
                    if (ack_i) begin
                        alert_success_o <= 1'b1;
                        state_q         <= ST_IDLE;
                    end else if (ack_expired_i) begin
                        if (left_q != '0) begin
                            left_q  <= left_q - 1'b1;
                            state_q <= ST_LAUNCH;
                        end else begin
                            alert_fail_o <= 1'b1;
                            state_q      <= ST_IDLE;
                        end
                    end
                end
                ST_BIST: begin
                    if (bist_expired_i) begin
                        alert_success_o <= 1'b1;
                        state_q         <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pd_tx_retry_ctrl.sv
// Top of the PD transmit retry controller: configuration check, sequencer,
// acknowledgement window timer and BIST carrier duration timer.
// Assumes all inputs are synchronous to clk; reset is synchronous active low.
module pd_tx_retry_ctrl
    import pd_txr_pkg::*;
#(
    parameter int unsigned ACK_TIMEOUT_CYC = 50_000,
    parameter int unsigned BIST_CYC        = 2_500_000,
    parameter int unsigned CNT_W           = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       frame_type_i,
    input  logic [1:0]       retry_cnt_i,
    input  logic [CNT_W-1:0] byte_cnt_i,
    input  logic             rx_msg_i,
    input  logic             phy_done_i,
    input  logic             ack_i,
    output logic             phy_req_o,
    output logic [2:0]       phy_type_o,
    output logic             busy_o,
    output logic             bist_active_o,
    output logic             alert_success_o,
    output logic             alert_discard_o,
    output logic             alert_fail_o
);

    localparam int unsigned RETRY_W = 2;

    logic is_reset;
    logic is_bist;
    logic count_ok;
    logic ack_run;
    logic ack_expired;
    logic bist_run;
    logic bist_expired;

    pd_txr_cfg_check #(
        .CNT_W     (CNT_W),
        .MIN_BYTES (MSG_MIN_BYTES),
        .MAX_BYTES (MSG_MAX_BYTES)
    ) u_cfg (
        .frame_type_i (frame_type_i),
        .byte_cnt_i   (byte_cnt_i),
        .is_reset_o   (is_reset),
        .is_bist_o    (is_bist),
        .count_ok_o   (count_ok)
    );

    pd_txr_fsm #(
        .RETRY_W (RETRY_W)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .frame_type_i    (frame_type_i),
        .retry_i         (retry_cnt_i),
        .is_reset_i      (is_reset),
        .is_bist_i       (is_bist),
        .count_ok_i      (count_ok),
        .rx_msg_i        (rx_msg_i),
        .phy_done_i      (phy_done_i),
        .ack_i           (ack_i),
        .ack_expired_i   (ack_expired),
        .bist_expired_i  (bist_expired),
        .phy_req_o       (phy_req_o),
        .phy_type_o      (phy_type_o),
        .ack_run_o       (ack_run),
        .bist_run_o      (bist_run),
        .busy_o          (busy_o),
        .alert_success_o (alert_success_o),
        .alert_discard_o (alert_discard_o),
        .alert_fail_o    (alert_fail_o)
    );

    pd_txr_window #(
        .LIMIT (ACK_TIMEOUT_CYC)
    ) u_ack_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ack_run),
        .expired_o (ack_expired)
    );

    pd_txr_window #(
        .LIMIT (BIST_CYC)
    ) u_bist_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (bist_run),
        .expired_o (bist_expired)
    );

    // The carrier window is exactly the time the BIST timer runs.
    assign bist_active_o = bist_run;

endmodule

// File: rtl/pd_txr_checker.sv
// Protocol checks on the controller's ports, attached by bind.
// Assumes the same clock and synchronous active-low reset as the design.
module pd_txr_checker #(
    parameter int unsigned BIST_CYC = 2_500_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_msg_i,
    input logic       phy_done_i,
    input logic       phy_req_o,
    input logic [2:0] phy_type_o,
    input logic       busy_o,
    input logic       bist_active_o,
    input logic       alert_success_o,
    input logic       alert_discard_o,
    input logic       alert_fail_o
);

    int unsigned carrier_len;

    // Length of the current run of carrier cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carrier_len <= 0;
        end else if (bist_active_o) begin
            carrier_len <= carrier_len + 1;
        end else begin
            carrier_len <= 0;
        end
    end

    // R10
    alert_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({alert_success_o, alert_discard_o, alert_fail_o}));

    // R10
    alert_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_success_o || alert_discard_o || alert_fail_o) |-> !busy_o);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req_o && !phy_done_i) |=> phy_req_o);

    // R2
    req_type_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req_o && $past(phy_req_o)) |-> $stable(phy_type_o));

    // R6
    launch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_req_o) |-> !$past(rx_msg_i));

    // R8
    bist_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bist_active_o |-> !phy_req_o);

    // R8
    bist_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bist_active_o) |-> (carrier_len == BIST_CYC));

    // R8
    bist_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bist_active_o) |-> alert_success_o);

endmodule

bind pd_tx_retry_ctrl pd_txr_checker #(
    .BIST_CYC (BIST_CYC)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rx_msg_i        (rx_msg_i),
    .phy_done_i      (phy_done_i),
    .phy_req_o       (phy_req_o),
    .phy_type_o      (phy_type_o),
    .busy_o          (busy_o),
    .bist_active_o   (bist_active_o),
    .alert_success_o (alert_success_o),
    .alert_discard_o (alert_discard_o),
    .alert_fail_o    (alert_fail_o)
);

// File: tb/tb_pd_tx_retry_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked by one loop with a simple PHY
// model, then directed tests for reset, busy-ignore and mid-run reset.
module tb_pd_tx_retry_ctrl;

    localparam int unsigned TO_CYC   = 8;
    localparam int unsigned BIST_LEN = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] ftype = 3'd0;
    logic [1:0] retry = 2'd0;
    logic [7:0] bcnt  = 8'd0;
    logic       rx    = 1'b0;
    logic       done  = 1'b0;
    logic       ack   = 1'b0;
    logic       req;
    logic [2:0] ptype;
    logic       busy;
    logic       bist;
    logic       a_ok;
    logic       a_disc;
    logic       a_fail;

    int tests_run = 0;
    int tests_failed = 0;

    always #10 clk = ~clk;

    pd_tx_retry_ctrl #(
        .ACK_TIMEOUT_CYC (TO_CYC),
        .BIST_CYC        (BIST_LEN),
        .CNT_W           (8)
    ) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start),
        .frame_type_i    (ftype),
        .retry_cnt_i     (retry),
        .byte_cnt_i      (bcnt),
        .rx_msg_i        (rx),
        .phy_done_i      (done),
        .ack_i           (ack),
        .phy_req_o       (req),
        .phy_type_o      (ptype),
        .busy_o          (busy),
        .bist_active_o   (bist),
        .alert_success_o (a_ok),
        .alert_discard_o (a_disc),
        .alert_fail_o    (a_fail)
    );

    // Outcome codes: 1 success, 2 discard, 3 fail.
    typedef struct packed {
        logic [2:0] ft;
        logic [1:0] rt;
        logic [7:0] bc;
        logic       rx;
        logic [2:0] ack_on;
        logic [3:0] dly;
        logic [1:0] out;
        logic [2:0] att;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 2'd0, 8'd2,  1'b0, 3'd1, 4'd3, 2'd1, 3'd1},
        '{3'd1, 2'd1, 8'd30, 1'b0, 3'd2, 4'd8, 2'd1, 3'd2},
        '{3'd2, 2'd2, 8'd10, 1'b0, 3'd0, 4'd1, 2'd3, 3'd3},
        '{3'd3, 2'd3, 8'd6,  1'b0, 3'd0, 4'd1, 2'd3, 3'd4},
        '{3'd4, 2'd3, 8'd14, 1'b0, 3'd4, 4'd1, 2'd1, 3'd4},
        '{3'd0, 2'd0, 8'd6,  1'b0, 3'd1, 4'd9, 2'd3, 3'd1},
        '{3'd0, 2'd2, 8'd6,  1'b1, 3'd0, 4'd1, 2'd2, 3'd0},
        '{3'd0, 2'd0, 8'd1,  1'b0, 3'd0, 4'd1, 2'd3, 3'd0},
        '{3'd0, 2'd0, 8'd31, 1'b0, 3'd0, 4'd1, 2'd3, 3'd0},
        '{3'd5, 2'd3, 8'd0,  1'b0, 3'd0, 4'd1, 2'd1, 3'd1},
        '{3'd6, 2'd2, 8'd0,  1'b0, 3'd0, 4'd1, 2'd1, 3'd1},
        '{3'd7, 2'd1, 8'd0,  1'b0, 3'd0, 4'd1, 2'd1, 3'd0},
        '{3'd0, 2'd1, 8'd0,  1'b1, 3'd0, 4'd1, 2'd3, 3'd0}
    };

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests_run++;
        if (act != exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.ft == 3'd7) return "R8";
        if (v.ft == 3'd5 || v.ft == 3'd6) return "R7";
        if (v.bc < 8'd2 || v.bc > 8'd30) return "R9";
        if (v.rx) return "R6";
        if (v.ack_on != 3'd0 && 32'(v.dly) > TO_CYC) return "R12";
        if (v.out == 2'd3) return "R5";
        if (v.att > 3'd1) return "R4";
        return "R3";
    endfunction

    // Drive one request, model the PHY, and check outcome, attempts and pulses.
    task automatic run_case(input vec_t v, input bit mid_start);
        int outcome = 0;
        int pulses = 0;
        int att = 0;
        int mism = 0;
        int bcyc = 0;
        int post = 0;
        int ack_cd = 0;
        bit prev_req = 1'b0;
        bit done_now;
        string tg;
        tg = mid_start ? "R11" : tag_of(v);
        @(negedge clk);
        start = 1'b1; ftype = v.ft; retry = v.rt; bcnt = v.bc; rx = v.rx;
        for (int it = 0; it < 600; it++) begin
            @(negedge clk);
            // sample
            if (a_ok || a_disc || a_fail) begin
                pulses++;
                if (outcome == 0) outcome = a_ok ? 1 : (a_disc ? 2 : 3);
            end
            if (req && ptype != v.ft) mism++;
            done_now = req && !prev_req;
            if (done_now) att++;
            if (bist) bcyc++;
            prev_req = req;
            // drive
            start = 1'b0;
            if (mid_start && (it == 1 || it == 3)) begin
                start = 1'b1; ftype = 3'd6;
            end else begin
                ftype = v.ft;
            end
            if (it >= 1) rx = 1'b0;
            done = done_now;
            ack = 1'b0;
            if (ack_cd > 0) begin
                ack_cd--;
                if (ack_cd == 0) ack = 1'b1;
            end
            if (done_now && att == int'(v.ack_on)) ack_cd = int'(v.dly);
            if (outcome != 0) post++;
            if (post >= 12) break;
        end
        done = 1'b0; ack = 1'b0; start = 1'b0; rx = 1'b0;
        chk(tg, "outcome", outcome, int'(v.out));
        chk((v.ft == 3'd5 || v.ft == 3'd6) ? "R7" : "R4", "attempts", att, int'(v.att));
        chk("R10", "outcome pulses", pulses, 1);
        chk("R2", "phy_type mismatches", mism, 0);
        if (v.ft == 3'd7) chk("R8", "carrier cycles", bcyc, int'(BIST_LEN));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        int seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "phy_req", int'(req), 0);
        chk("R1", "bist_active", int'(bist), 0);
        chk("R1", "alerts", int'({a_ok, a_disc, a_fail}), 0);

        for (int i = 0; i < NV; i++) begin
            run_case(VEC[i], 1'b0);
        end

        // R11: second start while busy is ignored
        run_case('{3'd0, 2'd0, 8'd2, 1'b0, 3'd1, 4'd2, 2'd1, 3'd1}, 1'b1);
        chk("R11", "busy after outcome", int'(busy), 0);

        // R1: reset during the acknowledgement wait
        @(negedge clk);
        start = 1'b1; ftype = 3'd0; retry = 2'd3; bcnt = 8'd6;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 10; k++) begin
            if (req) break;
            @(negedge clk);
        end
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        seen = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (busy || req || a_ok || a_disc || a_fail) seen++;
        end
        chk("R1", "activity after mid-run reset", seen, 0);

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule